// File: doc/BRIEF.md
# Multi-thread load/store queue share limiter

Several hardware threads can share one load queue and one store queue. This block keeps a per-thread occupancy count for each of the two queues and decides whether a new entry may be taken. The entries themselves are held elsewhere; only the counts and the admission decision are kept here. The limit on each thread depends on the sharing policy, which is chosen at run time. In the fully shared policy any thread may take any free slot. In the split policy each active thread gets an equal integer share. In the capped policy each thread is held to a limit given on an input.

An allocation is a valid/ready handshake, one per queue, and it carries a thread number. The entry is taken in a cycle only when valid and ready are both high. Ready is computed from the current counts, the policy, the active-thread mask and the thread number. It does not depend on valid, so the producer may look at ready before it raises valid. A producer refused with ready low keeps valid up or retries later; a refused request leaves no trace. A release is a plain single-cycle pulse with a thread number and has no back-pressure. The block reports, for each thread, full, empty and free-slot counts, along with queue-wide full, empty and drained status and a configuration error flag.

Top module: `lsq_share_limiter`

## Requirements
- R1: After reset every count is zero, so lq_empty, sq_empty and drained are 1, and each thread's free count equals its cap: 8 for the load side and 12 for the store side under the fully shared policy with the default sizes.
- R2: An allocation is taken only when valid and ready are both high, and it adds one to that thread's count. A release pulse takes one away. A release for a thread whose count is already zero is ignored.
- R3: pol_sel 2'b01 selects the split policy. The cap of each thread is the queue depth divided by the number of set bits in active_mask, rounded down. Ready is low for a thread at its cap, and a refused request changes no count.
- R4: pol_sel 2'b00 selects the fully shared policy. Every thread's cap is the queue depth. Each bit of the per-thread full vector equals the queue-wide full flag. The queue-wide flag is set when the total occupancy reaches the depth or any thread reaches its cap, and ready is then low for every thread.
- R5: pol_sel 2'b10 selects the capped policy. A thread's cap is the smaller of share_limit and the queue depth. A thread reports full only when its own count reaches its cap.
- R6: cfg_err is high when pol_sel is 2'b11, or when pol_sel is 2'b10 and share_limit is not greater than both queue depths. While cfg_err is high, ready is low on both queues.
- R7: A thread's free count is its cap minus its count. It is zero when the count is at or above the cap, as happens after the cap shrinks because more threads became active.
- R8: lsq_full is high when either the load side or the store side is full.
- R9: drained is high only when every thread has a zero count on both queues. thr_empty bit t is high when thread t holds nothing on either queue.
- R10: An accepted allocation and a release for the same thread in the same cycle leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_sel | input | 2 | Sharing policy: 00 shared, 01 split, 10 capped, 11 invalid |
| share_limit | input | LIM_W | Per-thread limit used by the capped policy |
| active_mask | input | NT | Threads counted by the split policy |
| ld_alloc_valid | input | 1 | Load-queue allocation request |
| ld_alloc_tid | input | TW | Thread of the load allocation |
| ld_alloc_ready | output | 1 | Load allocation may be taken this cycle |
| ld_free_vld | input | 1 | Load-queue release pulse |
| ld_free_tid | input | TW | Thread of the load release |
| st_alloc_valid | input | 1 | Store-queue allocation request |
| st_alloc_tid | input | TW | Thread of the store allocation |
| st_alloc_ready | output | 1 | Store allocation may be taken this cycle |
| st_free_vld | input | 1 | Store-queue release pulse |
| st_free_tid | input | TW | Thread of the store release |
| thr_ld_full | output | NT | Per-thread load-side full |
| thr_st_full | output | NT | Per-thread store-side full |
| thr_empty | output | NT | Per-thread empty on both queues |
| ld_free_flat | output | NT*LCW | Per-thread load free counts, thread t at bits t*LCW upward |
| st_free_flat | output | NT*SCW | Per-thread store free counts, thread t at bits t*SCW upward |
| lq_full | output | 1 | Load side full |
| sq_full | output | 1 | Store side full |
| lsq_full | output | 1 | Either side full |
| lq_empty | output | 1 | Load queue holds nothing |
| sq_empty | output | 1 | Store queue holds nothing |
| drained | output | 1 | Both queues hold nothing |
| cfg_err | output | 1 | Invalid policy or capped-policy limit |

## Verification
The hardest case to reach is a thread whose count exceeds its cap. No allocation can cause it, because the cap refuses the entry first. The stimulus gets there by filling one thread under the split policy with only two threads active, and then widening active_mask so that the share drops below what the thread already holds. The bench then checks that the free count is clamped at zero and the thread reads full. The other case needing care is a policy change while the load queue is full: the shared and capped policies must then report different per-thread full vectors for the same counts.

// File: rtl/lsl_pkg.sv
package lsl_pkg;
  typedef enum logic [1:0] {
    POL_SHARED = 2'b00,
    POL_SPLIT  = 2'b01,
    POL_CAPPED = 2'b10,
    POL_BAD    = 2'b11
  } share_pol_e;
endpackage

// File: rtl/lsl_cap_calc.sv
module lsl_cap_calc
  import lsl_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NT    = 4,
  parameter int LIM_W = 6,
  parameter int CW    = 4
) (
  input  share_pol_e        pol,
  input  logic [NT-1:0]     active_mask,
  input  logic [LIM_W-1:0]  share_limit,
  output logic [CW-1:0]     cap
);
  localparam int PW = $clog2(NT + 1);

  logic [CW-1:0] part_tab [NT+1];
  logic [PW-1:0] n_act;

  // Split shares are computed when the design is built: entry k holds DEPTH/k.
  for (genvar k = 0; k <= NT; k++) begin : g_tab
    assign part_tab[k] = (k == 0) ? '0 : CW'(DEPTH / ((k == 0) ? 1 : k));
  end

  always_comb begin
    n_act = '0;
    for (int i = 0; i < NT; i++) n_act = n_act + PW'(active_mask[i]);
  end

  always_comb begin
    case (pol)
      POL_SPLIT:  cap = part_tab[n_act];
      POL_CAPPED: cap = (int'(share_limit) >= DEPTH) ? CW'(DEPTH) : CW'(share_limit);
      default:    cap = CW'(DEPTH);
    endcase
  end
endmodule

// File: rtl/lsl_side.sv
module lsl_side #(
  parameter int NT    = 4,
  parameter int DEPTH = 8,
  parameter int CW    = 4,
  parameter int TW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dyn_mode,
  input  logic             block,
  input  logic [CW-1:0]    cap,
  input  logic             alloc_valid,
  input  logic [TW-1:0]    alloc_tid,
  output logic             alloc_ready,
  input  logic             free_vld,
  input  logic [TW-1:0]    free_tid,
  output logic [NT-1:0]    thr_full,
  output logic [NT-1:0]    thr_empty,
  output logic [NT*CW-1:0] free_flat,
  output logic             side_full,
  output logic             side_empty
);
  localparam int TOT_W = $clog2(NT * DEPTH + 1);

  logic [CW-1:0]    occ [NT];
  logic [NT-1:0]    own_full;
  logic [TOT_W-1:0] total;

  always_comb begin
    total = '0;
    for (int i = 0; i < NT; i++) total = total + TOT_W'(occ[i]);
  end

  assign side_full   = (|own_full) || (int'(total) >= DEPTH);
  assign side_empty  = (total == '0);
  assign alloc_ready = !block && !own_full[alloc_tid] && (int'(total) < DEPTH);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic inc, dec;
    assign inc = alloc_valid && alloc_ready && (alloc_tid == TW'(t));
    assign dec = free_vld && (free_tid == TW'(t)) && (occ[t] != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) occ[t] <= '0;
      else if (inc && !dec) occ[t] <= occ[t] + 1'b1;
      else if (dec && !inc) occ[t] <= occ[t] - 1'b1;
    end

    assign own_full[t]            = (occ[t] >= cap);
    assign thr_full[t]            = dyn_mode ? side_full : own_full[t];
    assign thr_empty[t]           = (occ[t] == '0);
    assign free_flat[t*CW +: CW]  = own_full[t] ? '0 : (cap - occ[t]);
  end
endmodule

// File: rtl/lsq_share_limiter.sv
module lsq_share_limiter
  import lsl_pkg::*;
#(
  parameter int  NT       = 4,
  parameter int  LQ_DEPTH = 8,
  parameter int  SQ_DEPTH = 12,
  parameter int  LIM_W    = 6,
  localparam int TW       = (NT > 1) ? $clog2(NT) : 1,
  localparam int LCW      = $clog2(LQ_DEPTH + 1),
  localparam int SCW      = $clog2(SQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pol_sel,
  input  logic [LIM_W-1:0]  share_limit,
  input  logic [NT-1:0]     active_mask,
  input  logic              ld_alloc_valid,
  input  logic [TW-1:0]     ld_alloc_tid,
  output logic              ld_alloc_ready,
  input  logic              ld_free_vld,
  input  logic [TW-1:0]     ld_free_tid,
  input  logic              st_alloc_valid,
  input  logic [TW-1:0]     st_alloc_tid,
  output logic              st_alloc_ready,
  input  logic              st_free_vld,
  input  logic [TW-1:0]     st_free_tid,
  output logic [NT-1:0]     thr_ld_full,
  output logic [NT-1:0]     thr_st_full,
  output logic [NT-1:0]     thr_empty,
  output logic [NT*LCW-1:0] ld_free_flat,
  output logic [NT*SCW-1:0] st_free_flat,
  output logic              lq_full,
  output logic              sq_full,
  output logic              lsq_full,
  output logic              lq_empty,
  output logic              sq_empty,
  output logic              drained,
  output logic              cfg_err
);
  share_pol_e     pol;
  logic [LCW-1:0] ld_cap;
  logic [SCW-1:0] st_cap;
  logic [NT-1:0]  ld_thr_empty, st_thr_empty;
  logic           dyn_mode;

  assign pol      = share_pol_e'(pol_sel);
  assign dyn_mode = (pol == POL_SHARED);
  assign cfg_err  = (pol == POL_BAD) ||
                    ((pol == POL_CAPPED) &&
                     ((int'(share_limit) <= LQ_DEPTH) || (int'(share_limit) <= SQ_DEPTH)));

  lsl_cap_calc #(.DEPTH(LQ_DEPTH), .NT(NT), .LIM_W(LIM_W), .CW(LCW)) u_ld_cap (
    .pol(pol), .active_mask(active_mask), .share_limit(share_limit), .cap(ld_cap));

  lsl_cap_calc #(.DEPTH(SQ_DEPTH), .NT(NT), .LIM_W(LIM_W), .CW(SCW)) u_st_cap (
    .pol(pol), .active_mask(active_mask), .share_limit(share_limit), .cap(st_cap));

  lsl_side #(.NT(NT), .DEPTH(LQ_DEPTH), .CW(LCW), .TW(TW)) u_ld_side (
    .clk(clk), .rst_n(rst_n), .dyn_mode(dyn_mode), .block(cfg_err), .cap(ld_cap),
    .alloc_valid(ld_alloc_valid), .alloc_tid(ld_alloc_tid), .alloc_ready(ld_alloc_ready),
    .free_vld(ld_free_vld), .free_tid(ld_free_tid),
    .thr_full(thr_ld_full), .thr_empty(ld_thr_empty), .free_flat(ld_free_flat),
    .side_full(lq_full), .side_empty(lq_empty));

  lsl_side #(.NT(NT), .DEPTH(SQ_DEPTH), .CW(SCW), .TW(TW)) u_st_side (
    .clk(clk), .rst_n(rst_n), .dyn_mode(dyn_mode), .block(cfg_err), .cap(st_cap),
    .alloc_valid(st_alloc_valid), .alloc_tid(st_alloc_tid), .alloc_ready(st_alloc_ready),
    .free_vld(st_free_vld), .free_tid(st_free_tid),
    .thr_full(thr_st_full), .thr_empty(st_thr_empty), .free_flat(st_free_flat),
    .side_full(sq_full), .side_empty(sq_empty));

  assign thr_empty = ld_thr_empty & st_thr_empty;
  assign lsq_full  = lq_full || sq_full;
  assign drained   = lq_empty && sq_empty;
endmodule

// File: rtl/lsq_share_limiter_chk.sv
module lsq_share_limiter_chk #(
  parameter int NT  = 4,
  parameter int TW  = 2,
  parameter int LCW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        pol_sel,
  input logic              cfg_err,
  input logic [TW-1:0]     ld_alloc_tid,
  input logic              ld_alloc_ready,
  input logic              st_alloc_ready,
  input logic              lq_full,
  input logic              drained,
  input logic [NT-1:0]     thr_ld_full,
  input logic [NT-1:0]     thr_empty,
  input logic [NT*LCW-1:0] ld_free_flat
);
  p_cfg_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!ld_alloc_ready && !st_alloc_ready));

  p_full_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    thr_ld_full[ld_alloc_tid] |-> !ld_alloc_ready);

  p_shared_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_sel == 2'b00 && lq_full) |-> (thr_ld_full == {NT{1'b1}}));

  p_free_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_sel != 2'b00 && thr_ld_full[0]) |-> (ld_free_flat[LCW-1:0] == '0));

  p_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> (thr_empty == {NT{1'b1}}));
endmodule

bind lsq_share_limiter lsq_share_limiter_chk #(.NT(NT), .TW(TW), .LCW(LCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .cfg_err(cfg_err),
  .ld_alloc_tid(ld_alloc_tid), .ld_alloc_ready(ld_alloc_ready),
  .st_alloc_ready(st_alloc_ready), .lq_full(lq_full), .drained(drained),
  .thr_ld_full(thr_ld_full), .thr_empty(thr_empty), .ld_free_flat(ld_free_flat));

// File: tb/lsq_share_limiter_tb.sv
`timescale 1ns/1ps
module lsq_share_limiter_tb_top;
  localparam int NT = 4, LQ = 8, SQ = 12, LIM_W = 6;
  localparam int TW = 2, LCW = 4, SCW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pol_sel = 2'b00;
  logic [LIM_W-1:0] share_limit = 6'd13;
  logic [NT-1:0] active_mask = 4'hF;
  logic ld_alloc_valid = 1'b0, ld_free_vld = 1'b0, st_alloc_valid = 1'b0, st_free_vld = 1'b0;
  logic [TW-1:0] ld_alloc_tid = '0, ld_free_tid = '0, st_alloc_tid = '0, st_free_tid = '0;
  logic ld_alloc_ready, st_alloc_ready;
  logic [NT-1:0] thr_ld_full, thr_st_full, thr_empty;
  logic [NT*LCW-1:0] ld_free_flat;
  logic [NT*SCW-1:0] st_free_flat;
  logic lq_full, sq_full, lsq_full, lq_empty, sq_empty, drained, cfg_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lsq_share_limiter #(.NT(NT), .LQ_DEPTH(LQ), .SQ_DEPTH(SQ), .LIM_W(LIM_W)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ldfree(input int t);
    return int'(ld_free_flat[t*LCW +: LCW]);
  endfunction

  function automatic int stfree(input int t);
    return int'(st_free_flat[t*SCW +: SCW]);
  endfunction

  task automatic ld_alloc(input int tid, output bit rdy);
    @(negedge clk);
    ld_alloc_valid = 1'b1; ld_alloc_tid = TW'(tid);
    #1 rdy = ld_alloc_ready;
    @(negedge clk);
    ld_alloc_valid = 1'b0;
  endtask

  task automatic ld_rel(input int tid);
    @(negedge clk);
    ld_free_vld = 1'b1; ld_free_tid = TW'(tid);
    @(negedge clk);
    ld_free_vld = 1'b0;
  endtask

  task automatic st_alloc(input int tid, output bit rdy);
    @(negedge clk);
    st_alloc_valid = 1'b1; st_alloc_tid = TW'(tid);
    #1 rdy = st_alloc_ready;
    @(negedge clk);
    st_alloc_valid = 1'b0;
  endtask

  task automatic st_rel(input int tid);
    @(negedge clk);
    st_free_vld = 1'b1; st_free_tid = TW'(tid);
    @(negedge clk);
    st_free_vld = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] p, input int lim, input logic [NT-1:0] m);
    @(negedge clk);
    pol_sel = p; share_limit = LIM_W'(lim); active_mask = m;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 drained", int'(drained), 1);
    chk("R1 lq_empty", int'(lq_empty), 1);
    chk("R1 sq_empty", int'(sq_empty), 1);
    chk("R1 ld free t0", ldfree(0), 8);
    chk("R1 st free t3", stfree(3), 12);
    chk("R1 cfg_err", int'(cfg_err), 0);
  endtask

  task automatic t_split;
    bit r;
    set_cfg(2'b01, 13, 4'hF);
    ld_alloc(1, r); chk("R2 first alloc ready", int'(r), 1);
    chk("R2 count rose", ldfree(1), 1);
    ld_alloc(1, r); chk("R3 second alloc ready", int'(r), 1);
    ld_alloc(1, r); chk("R3 refused at cap", int'(r), 0);
    chk("R3 free t1 after refusal", ldfree(1), 0);
    chk("R3 full vector", int'(thr_ld_full), 4'b0010);
    chk("R3 other thread free", ldfree(0), 2);
    set_cfg(2'b01, 13, 4'b0111);
    chk("R3 store share of three", stfree(0), 4);
    chk("R3 load share of three", ldfree(2), 2);
    ld_rel(1); ld_rel(1); ld_rel(1);
    ld_alloc(1, r);
    chk("R2 release at zero ignored", ldfree(1), 1);
    ld_rel(1);
  endtask

  task automatic t_shrink;
    bit r;
    set_cfg(2'b01, 13, 4'b0011);
    for (int i = 0; i < 3; i++) ld_alloc(0, r);
    chk("R7 free below cap", ldfree(0), 1);
    ld_alloc(0, r);
    set_cfg(2'b01, 13, 4'hF);
    chk("R7 free clamped", ldfree(0), 0);
    chk("R7 over-cap thread full", int'(thr_ld_full[0]), 1);
    chk("R7 peer free", ldfree(1), 2);
    for (int i = 0; i < 4; i++) ld_rel(0);
    chk("R7 emptied", int'(lq_empty), 1);
  endtask

  task automatic t_shared_and_capped;
    bit r;
    set_cfg(2'b00, 13, 4'hF);
    for (int i = 0; i < 4; i++) ld_alloc(0, r);
    for (int i = 0; i < 4; i++) ld_alloc(1, r);
    chk("R4 last alloc ready", int'(r), 1);
    chk("R4 lq_full", int'(lq_full), 1);
    chk("R4 full vector all", int'(thr_ld_full), 4'hF);
    ld_alloc(2, r); chk("R4 idle thread refused", int'(r), 0);
    chk("R4 refused count unchanged", ldfree(2), 8);
    chk("R8 lsq_full", int'(lsq_full), 1);
    chk("R8 sq_full", int'(sq_full), 0);
    set_cfg(2'b10, 13, 4'hF);
    chk("R5 cfg ok", int'(cfg_err), 0);
    chk("R5 no thread full", int'(thr_ld_full), 0);
    chk("R5 queue still full", int'(lq_full), 1);
    chk("R5 free t0", ldfree(0), 4);
    for (int i = 0; i < 4; i++) begin ld_rel(0); ld_rel(1); end
    for (int i = 0; i < 8; i++) ld_alloc(2, r);
    chk("R5 own cap reached", int'(thr_ld_full), 4'b0100);
    for (int i = 0; i < 8; i++) ld_rel(2);
  endtask

  task automatic t_cfg;
    bit r;
    set_cfg(2'b10, 12, 4'hF);
    chk("R6 limit not above store depth", int'(cfg_err), 1);
    ld_alloc(0, r); chk("R6 load refused", int'(r), 0);
    chk("R6 load queue untouched", int'(lq_empty), 1);
    set_cfg(2'b11, 13, 4'hF);
    chk("R6 invalid policy", int'(cfg_err), 1);
    st_alloc(0, r); chk("R6 store refused", int'(r), 0);
    set_cfg(2'b10, 13, 4'hF);
    chk("R6 valid limit", int'(cfg_err), 0);
  endtask

  task automatic t_same_cycle;
    bit r;
    set_cfg(2'b00, 13, 4'hF);
    ld_alloc(3, r);
    @(negedge clk);
    ld_alloc_valid = 1'b1; ld_alloc_tid = 2'd3;
    ld_free_vld = 1'b1; ld_free_tid = 2'd3;
    @(negedge clk);
    ld_alloc_valid = 1'b0; ld_free_vld = 1'b0;
    chk("R10 net unchanged", ldfree(3), 7);
    ld_rel(3);
  endtask

  task automatic t_drain;
    bit r;
    st_alloc(1, r);
    chk("R9 sq_empty", int'(sq_empty), 0);
    chk("R9 lq_empty", int'(lq_empty), 1);
    chk("R9 not drained", int'(drained), 0);
    chk("R9 thr_empty", int'(thr_empty), 4'b1101);
    st_rel(1);
    chk("R9 drained again", int'(drained), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset;
    t_split;
    t_shrink;
    t_shared_and_capped;
    t_cfg;
    t_same_cycle;
    t_drain;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule